// File: doc/BRIEF.md
# Reactive Signal I/O Unit

This unit sits beside the control unit of a small processor. It gives the processor's instructions direct access to sixteen environment input lines and sixteen output lines, with no memory or port decoding in between. Each instruction cycle the control unit presents one decoded reactive operation, with up to two line indices and a branch target. The unit returns three things: a stall request, a branch decision with its address, and a registered output word.

The environment lines are captured into a register at every clock edge, and each clock edge starts one instruction cycle. Every test made during a cycle uses that captured copy. There are two kinds of output drive. A pulse lasts exactly one instruction cycle. A latched drive stays on until reset. The output word is the OR of the two.

The unit handles three kinds of test:
- A single-line wait stalls the core until the line is seen.
- A two-line wait stalls until either line is seen. It falls through when the first line is present, and branches when only the second is present.
- A presence test never stalls. It falls through when the line is present and branches when it is absent.

The pulse and latch operations are one-word instructions, and so is the single-line wait. The two-line wait and the presence test carry a branch target as a second word. Fetching that word is the job of the surrounding core.

Top module: `rio_unit`

## Requirements
- R1: A synchronous active-low reset clears the output word and the captured input copy. While reset is held, `sig_out` reads 0 at every clock edge.
- R2: An operation with `op_code` 3'd1 (pulse) and index `sig_a` accepted at edge k drives `sig_out[sig_a]` high in the cycle after edge k+1. It drives no other bit. The bit returns low after edge k+2 unless it is latched.
- R3: An operation with `op_code` 3'd2 (latch) and index `sig_a` sets `sig_out[sig_a]`. The bit stays high from then on until reset, whatever operations follow.
- R4: The output word is the bitwise OR of the latched bits and the pulse bits. A pulse on a line that is already latched leaves that line high after the pulse ends.
- R5: With `op_code` 3'd3 (single-line wait), `stall` is high exactly when captured input `sig_a` is absent. `br_taken` stays low.
- R6: With `op_code` 3'd4 (two-line wait), the unit reacts to captured inputs `sig_a` and `sig_b` as follows. If `sig_a` is present, `stall` and `br_taken` are both low. If only `sig_b` is present, `br_taken` is high and `br_addr` equals `br_target`. If neither is present, `stall` is high and `br_taken` is low.
- R7: In a two-line wait where both selected inputs are present, the first one wins. The unit falls through, with no stall and no branch.
- R8: With `op_code` 3'd5 (presence test), `stall` is never high. If captured input `sig_a` is present, `br_taken` is low. If it is absent, `br_taken` is high and `br_addr` equals `br_target`.
- R9: Every test uses the input word captured at the most recent clock edge. A change on `sens_in` after that edge has no effect on `stall` or `br_taken` until the next edge.
- R10: When `op_valid` is low, or `op_code` is 3'd0, the operation has no effect. `stall` and `br_taken` are low, and the output word does not change.
- R11: Pulse and latch operations never raise `stall` or `br_taken`, and `stall` and `br_taken` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge starts an instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sens_in | input | 16 | Environment input lines |
| op_valid | input | 1 | A decoded reactive operation is present this cycle |
| op_code | input | 3 | 0 none, 1 pulse, 2 latch, 3 single wait, 4 two-line wait, 5 presence test |
| sig_a | input | 4 | First line index |
| sig_b | input | 4 | Second line index (two-line wait only) |
| br_target | input | 16 | Branch address from the second instruction word |
| stall | output | 1 | Hold the program counter this cycle |
| br_taken | output | 1 | Load the program counter from br_addr |
| br_addr | output | 16 | Branch address, valid with br_taken |
| sig_out | output | 16 | Registered environment output lines |

## Verification
The bench sweeps every pair of indices in the two-line wait against all four presence combinations. That includes the case where both indices name the same line. A design that gives the second line priority would branch when both lines are present. A design that confuses the two branch senses would stall where it should fall through.

Pulses are swept on every line, to catch a pulse that lingers a second cycle or lands on the wrong bit. A pulse is also sent to a line that is already latched; a design that lets the pulse register overwrite the latch would drop that line.

The bench changes the input lines after the capture edge, in both directions. A unit that reads the live pins instead of the captured copy would flip its stall or branch decision mid-cycle.

// File: rtl/rio_pkg.sv
// Shared definitions for the reactive signal I/O unit.
// Assumes operation encodings are fixed by the instruction decoder.
package rio_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PULSE   = 3'd1,
        OP_LATCH   = 3'd2,
        OP_WAIT1   = 3'd3,
        OP_WAIT2   = 3'd4,
        OP_PRESENT = 3'd5
    } rio_op_t;

endpackage

// File: rtl/rio_sample.sv
// Captures the environment input lines once per instruction cycle.
// Assumes one clock edge per instruction cycle; inputs already synchronised.
module rio_sample #(
    parameter int N_SIG = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] sens_in,
    output logic [N_SIG-1:0] sens_q
);

    // Register the live lines; every test in the cycle reads this copy.
    always_ff @(posedge clk) begin
        if (!rst_n) sens_q <= '0;
        else        sens_q <= sens_in;
    end

endmodule

// File: rtl/rio_cond.sv
// Evaluates wait and presence tests against the captured inputs and
// produces the stall request and branch decision for the control unit.
// Purely combinational; assumes op fields are stable during the cycle.
module rio_cond
    import rio_pkg::*;
#(
    parameter int N_SIG  = 16,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic              op_valid,
    input  rio_op_t           op_code,
    input  logic [N_SIG-1:0]  sens_q,
    input  logic [IDX_W-1:0]  sig_a,
    input  logic [IDX_W-1:0]  sig_b,
    input  logic [ADDR_W-1:0] br_target,
    output logic              stall,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_addr
);

    logic hit_a;
    logic hit_b;

    // Look up the two selected lines in the captured word.
    always_comb begin
        hit_a = sens_q[sig_a];
        hit_b = sens_q[sig_b];
    end

    // Decide stall and branch; the first line of a two-line wait wins.
    always_comb begin
        stall    = 1'b0;
        br_taken = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OP_WAIT1:   stall = !hit_a;
                OP_WAIT2: begin
                    stall    = !hit_a && !hit_b;
                    br_taken = !hit_a &&  hit_b;
                end
                OP_PRESENT: br_taken = !hit_a;
                default: ;
            endcase
        end
    end

    // Present the target only alongside a taken branch.
    always_comb begin
        br_addr = br_taken ? br_target : '0;
    end

endmodule

// File: rtl/rio_drive.sv
// Holds the output drive: a latch register that only ever sets bits,
// and a pulse register that lives for exactly one instruction cycle.
// Assumes op fields are sampled at the clock edge that ends the cycle.
module rio_drive
    import rio_pkg::*;
#(
    parameter int N_SIG  = 16,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  rio_op_t          op_code,
    input  logic [IDX_W-1:0] sig_a,
    output logic [N_SIG-1:0] sus_q,
    output logic [N_SIG-1:0] pulse_q
);

    logic [N_SIG-1:0] sel_mask;

    // One-hot mask of the addressed line.
    always_comb begin
        sel_mask = N_SIG'(1) << sig_a;
    end

    // Latched drives accumulate until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sus_q <= '0;
        else if (op_valid && op_code == OP_LATCH)    sus_q <= sus_q | sel_mask;
    end

    // Pulse drives are rebuilt every cycle, so they last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pulse_q <= '0;
        else if (op_valid && op_code == OP_PULSE)    pulse_q <= sel_mask;
        else                                         pulse_q <= '0;
    end

endmodule

// File: rtl/rio_unit.sv
// Reactive signal I/O unit: instruction-level access to environment
// input and output lines for a processor's control unit.
// Assumes one instruction cycle per clock and a synchronous active-low reset.
module rio_unit
    import rio_pkg::*;
#(
    parameter int N_SIG  = 16,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SIG-1:0]  sens_in,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [IDX_W-1:0]  sig_a,
    input  logic [IDX_W-1:0]  sig_b,
    input  logic [ADDR_W-1:0] br_target,
    output logic              stall,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_addr,
    output logic [N_SIG-1:0]  sig_out
);

    rio_op_t          op_e;
    logic [N_SIG-1:0] sens_q;
    logic [N_SIG-1:0] sus_q;
    logic [N_SIG-1:0] pulse_q;

    // Interpret the raw opcode field as the shared operation type.
    always_comb begin
        op_e = rio_op_t'(op_code);
    end

    rio_sample #(.N_SIG(N_SIG)) i_sample (
        .clk     (clk),
        .rst_n   (rst_n),
        .sens_in (sens_in),
        .sens_q  (sens_q)
    );

    rio_cond #(.N_SIG(N_SIG), .ADDR_W(ADDR_W)) i_cond (
        .op_valid  (op_valid),
        .op_code   (op_e),
        .sens_q    (sens_q),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .br_target (br_target),
        .stall     (stall),
        .br_taken  (br_taken),
        .br_addr   (br_addr)
    );

    rio_drive #(.N_SIG(N_SIG)) i_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_e),
        .sig_a    (sig_a),
        .sus_q    (sus_q),
        .pulse_q  (pulse_q)
    );

    // Output word merges latched and pulsed drives.
    always_comb begin
        sig_out = sus_q | pulse_q;
    end

endmodule

// File: rtl/rio_unit_chk.sv
// Temporal checks on the reactive signal I/O unit, bound into rio_unit.
// Assumes reset is held low for at least two clock edges at start-up.
module rio_unit_chk #(
    parameter int N_SIG  = 16,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [IDX_W-1:0] sig_a,
    input logic             stall,
    input logic             br_taken,
    input logic [N_SIG-1:0] sig_out,
    input logic [N_SIG-1:0] sus_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (sig_out == '0));

    // R2
    pulse_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |=> sig_out[$past(sig_a)]);

    // R3
    latch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd2) |=> sus_q[$past(sig_a)]);

    // R3
    latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(sus_q)) & ~sus_q) == '0));

    // R4
    latch_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sus_q & ~sig_out) == '0));

    // R5
    wait1_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |-> !br_taken);

    // R8
    present_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |-> !stall);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!stall && !br_taken));

    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && br_taken));

endmodule

bind rio_unit rio_unit_chk #(.N_SIG(N_SIG)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .sig_a    (sig_a),
    .stall    (stall),
    .br_taken (br_taken),
    .sig_out  (sig_out),
    .sus_q    (sus_q)
);

// File: tb/test_rio_unit.sv
// Sweep bench for rio_unit: expected values are computed from the requirements.
module test_rio_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sens_in = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [3:0]  sig_a = '0;
    logic [3:0]  sig_b = '0;
    logic [15:0] br_target = '0;
    logic        stall;
    logic        br_taken;
    logic [15:0] br_addr;
    logic [15:0] sig_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rio_unit i_rio_unit (
        .clk(clk), .rst_n(rst_n), .sens_in(sens_in), .op_valid(op_valid),
        .op_code(op_code), .sig_a(sig_a), .sig_b(sig_b), .br_target(br_target),
        .stall(stall), .br_taken(br_taken), .br_addr(br_addr), .sig_out(sig_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; sens_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Capture a pattern: drive at negedge, capture at next posedge, return at negedge.
    task automatic capture(input logic [15:0] s);
        @(negedge clk);
        op_valid = 1'b0;
        sens_in = s;
        @(negedge clk);
    endtask

    // Decision check for a test operation, made mid-cycle after the capture.
    task automatic decide(input string req, input logic [2:0] op, input logic [3:0] a,
                          input logic [3:0] b, input logic [15:0] tgt,
                          input logic exp_st, input logic exp_br);
        op_valid = 1'b1; op_code = op; sig_a = a; sig_b = b; br_target = tgt;
        #1;
        chk(req, {31'd0, stall}, {31'd0, exp_st});
        chk(req, {31'd0, br_taken}, {31'd0, exp_br});
        if (exp_br) chk(req, {16'd0, br_addr}, {16'd0, tgt});
        op_valid = 1'b0;
    endtask

    initial begin
        #1;
        @(negedge clk);
        // R1: outputs cleared while reset held
        chk("R1", {16'd0, sig_out}, 32'd0);
        do_reset();
        chk("R1", {16'd0, sig_out}, 32'd0);

        // R2: pulse on every line, exactly one cycle
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'd1; sig_a = 4'(a);
            #1;
            chk("R2 R11", {30'd0, stall, br_taken}, 32'd0);
            @(negedge clk);
            op_valid = 1'b0;
            chk("R2", {16'd0, sig_out}, 32'(1) << a);
            @(negedge clk);
            chk("R2", {16'd0, sig_out}, 32'd0);
        end

        // R10: invalid or none operations leave outputs untouched
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd2; sig_a = 4'd7;
        #1;
        chk("R10", {30'd0, stall, br_taken}, 32'd0);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd0;
        #1;
        chk("R10", {30'd0, stall, br_taken}, 32'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", {16'd0, sig_out}, 32'd0);

        // R3 / R4: latch lines 3 and 12, then pulse latched line 3 and free line 5
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; sig_a = 4'd3;
        @(negedge clk);
        sig_a = 4'd12;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R3", {16'd0, sig_out}, 32'h1008);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; sig_a = 4'd3;
        @(negedge clk);
        sig_a = 4'd5;
        chk("R4", {16'd0, sig_out}, 32'h1008);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R4", {16'd0, sig_out}, 32'h1028);
        repeat (5) @(negedge clk);
        chk("R3", {16'd0, sig_out}, 32'h1008);
        do_reset();
        chk("R1", {16'd0, sig_out}, 32'd0);

        // R5 / R8: single wait and presence test, line present vs absent
        for (int a = 0; a < 16; a++) begin
            for (int p = 0; p < 2; p++) begin
                logic [15:0] pat;
                pat = p[0] ? (16'(1) << a) : ~(16'(1) << a);
                capture(pat);
                decide("R5", 3'd3, 4'(a), 4'd0, 16'hBEEF, !p[0], 1'b0);
                decide("R8", 3'd5, 4'(a), 4'd0, 16'(16'h4000 + a), 1'b0, !p[0]);
            end
        end

        // R6 / R7: two-line wait over all index pairs and presence combos
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [15:0] pat;
                    logic pa, pb;
                    pat = (c[0] ? (16'(1) << a) : 16'd0) | (c[1] ? (16'(1) << b) : 16'd0);
                    pa = pat[a];
                    pb = pat[b];
                    capture(pat);
                    decide((pa && pb) ? "R7" : "R6", 3'd4, 4'(a), 4'(b),
                           16'((a << 8) | (b << 4) | c), !pa && !pb, !pa && pb);
                end
            end
        end

        // R9: inputs changed after capture do not affect this cycle
        capture(16'h0004);
        sens_in = 16'h0000;
        decide("R9", 3'd3, 4'd2, 4'd0, 16'd0, 1'b0, 1'b0);
        capture(16'h0000);
        sens_in = 16'hFFFF;
        decide("R9", 3'd5, 4'd9, 4'd0, 16'h0909, 1'b0, 1'b1);
        @(negedge clk);
        decide("R9", 3'd5, 4'd9, 4'd0, 16'h0909, 1'b0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_vec++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule